// File: doc/BRIEF.md
# DRAM Mode Register Access Handshake

This block sits between a software-visible register interface and the DRAM command scheduler. It carries one mode register operation at a time. Software presents a one-cycle request strobe with a direction bit, a mode register address and write data. When the block is idle it takes the request into holding registers. A busy indication then guards the path until the operation has finished.

The block offers the captured operation to the scheduler as a single command over a valid/ready handshake. For a write, the operation ends when the scheduler reports that the command has gone out to the DRAM. For a read, it ends when the scheduler returns the read data. The returned data is stored in a readable register, and a valid flag goes with it. Software clears that flag by reading it. The flag also clears automatically whenever a new read command leaves the block.

Top module: `mr_access_ctl`

## Requirements
- R1: After a synchronous active-high reset, `busy`, `cmd_valid` and `rd_valid` are 0 and `rd_data` is all zeros.
- R2: A `req_stb` seen while `busy` is 0 is accepted. `busy` and `cmd_valid` are 1 from the next cycle on. `cmd_valid` is never 1 while `busy` is 0.
- R3: The direction bit `req_is_read` encodes 0 as a mode register write and 1 as a mode register read. The accepted direction, address and write data appear on `cmd_is_read`, `cmd_addr` and `cmd_wdata`.
- R4: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid` stays 1 and the command fields do not change. The command is handed over in the cycle where both are 1, and `cmd_valid` is 0 from the next cycle on.
- R5: For a write, `busy` falls in the cycle after a `wr_issued` pulse that arrives once the command has been handed over. `rd_return` has no effect on a write.
- R6: For a read, `busy` falls in the cycle after a `rd_return` pulse that arrives once the command has been handed over. `wr_issued` has no effect on a read.
- R7: A request strobed while `busy` is 1 is dropped and not queued. The command fields keep their values, and no second command follows when the current one finishes.
- R8: On the `rd_return` pulse that ends a read, `ret_data` is stored into `rd_data` and `rd_valid` becomes 1 in the next cycle. A write leaves `rd_data` and `rd_valid` unchanged.
- R9: `rd_valid` is 0 in the cycle after a read command is handed over to the scheduler.
- R10: A `flag_rd_stb` pulse clears `rd_valid` in the next cycle. If the flag is set in that same cycle, the set wins and `rd_valid` is 1.
- R11: `wr_issued` and `rd_return` pulses that arrive before the command has been handed over have no effect. `busy` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_stb | input | 1 | One-cycle software request strobe |
| req_is_read | input | 1 | Request direction, 0 write, 1 read |
| req_addr | input | AW | Mode register address of the request |
| req_wdata | input | DW | Write data of the request |
| busy | output | 1 | Operation in progress, new requests dropped |
| flag_rd_stb | input | 1 | Software read of the valid flag (clears it) |
| rd_valid | output | 1 | Read data register holds fresh data |
| rd_data | output | DW | Last returned mode register read data |
| cmd_valid | output | 1 | Command offered to the scheduler |
| cmd_ready | input | 1 | Scheduler takes the command |
| cmd_is_read | output | 1 | Command direction |
| cmd_addr | output | AW | Command mode register address |
| cmd_wdata | output | DW | Command write data |
| wr_issued | input | 1 | Pulse: write command sent to the DRAM |
| rd_return | input | 1 | Pulse: read data returned |
| ret_data | input | DW | Read data accompanying `rd_return` |

## Verification
Some properties hold on every cycle, and the assertions watch those. They cover the busy rise after acceptance, the stability of the command while the scheduler stalls, the direction-dependent release of busy, the frozen fields while busy, the valid flag clearing on a read handover and the clear-on-read. The bench sweeps both directions against every combination of scheduler stall length and response delay. Only those scenarios can show three further things: that dropped requests are never replayed, that wrong-kind pulses are truly ignored over long waits, and that `rd_data` holds each read's value across later writes. They also cover the same-cycle set-versus-clear collision and reset in the middle of an operation.

// File: rtl/mrac_pkg.sv
package mrac_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;

  // Completion depends on direction: writes end on issue, reads on data return.
  function automatic logic op_complete(input logic is_read,
                                       input logic wr_iss,
                                       input logic rd_ret);
    return is_read ? rd_ret : wr_iss;
  endfunction

  // Flag update: a set beats any clear in the same cycle.
  function automatic logic flag_next(input logic cur,
                                     input logic set_ev,
                                     input logic clr_ev);
    if (set_ev) return 1'b1;
    if (clr_ev) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/mrac_hold.sv
module mrac_hold #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          in_is_read,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_wdata,
  output logic          out_is_read,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_wdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_is_read <= 1'b0;
      out_addr    <= '0;
      out_wdata   <= '0;
    end else if (load) begin
      out_is_read <= in_is_read;
      out_addr    <= in_addr;
      out_wdata   <= in_wdata;
    end
  end

endmodule

// File: rtl/mrac_seq.sv
module mrac_seq
  import mrac_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_stb,
  input  logic op_is_read,
  input  logic cmd_ready,
  input  logic wr_issued,
  input  logic rd_return,
  output logic busy,
  output logic cmd_valid,
  output logic ev_accept,
  output logic ev_fire,
  output logic ev_done
);

  seq_state_e state_q, state_d;

  assign ev_accept = req_stb && (state_q == ST_IDLE);
  assign ev_fire   = (state_q == ST_SEND) && cmd_ready;
  assign ev_done   = (state_q == ST_WAIT) &&
                     op_complete(op_is_read, wr_issued, rd_return);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (ev_accept) state_d = ST_SEND;
      ST_SEND: if (ev_fire)   state_d = ST_WAIT;
      ST_WAIT: if (ev_done)   state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign busy      = (state_q != ST_IDLE);
  assign cmd_valid = (state_q == ST_SEND);

endmodule

// File: rtl/mrac_rbuf.sv
module mrac_rbuf
  import mrac_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [DW-1:0] cap_data,
  input  logic          clr_issue,
  input  logic          clr_sw,
  output logic [DW-1:0] data_q,
  output logic          valid_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (capture) data_q <= cap_data;
      valid_q <= flag_next(valid_q, capture, clr_issue | clr_sw);
    end
  end

endmodule

// File: rtl/mr_access_ctl.sv
module mr_access_ctl #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_stb,
  input  logic          req_is_read,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  input  logic          flag_rd_stb,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic          cmd_is_read,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_wdata,
  input  logic          wr_issued,
  input  logic          rd_return,
  input  logic [DW-1:0] ret_data
);

  // Named internal events, visible to the bound checker.
  logic ev_accept;
  logic ev_fire;
  logic ev_done;
  logic ev_rd_set;
  logic ev_rd_issue;

  mrac_hold #(.AW(AW), .DW(DW)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .load       (ev_accept),
    .in_is_read (req_is_read),
    .in_addr    (req_addr),
    .in_wdata   (req_wdata),
    .out_is_read(cmd_is_read),
    .out_addr   (cmd_addr),
    .out_wdata  (cmd_wdata)
  );

  mrac_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_stb   (req_stb),
    .op_is_read(cmd_is_read),
    .cmd_ready (cmd_ready),
    .wr_issued (wr_issued),
    .rd_return (rd_return),
    .busy      (busy),
    .cmd_valid (cmd_valid),
    .ev_accept (ev_accept),
    .ev_fire   (ev_fire),
    .ev_done   (ev_done)
  );

  assign ev_rd_set   = ev_done && cmd_is_read;
  assign ev_rd_issue = ev_fire && cmd_is_read;

  mrac_rbuf #(.DW(DW)) u_rbuf (
    .clk      (clk),
    .rst      (rst),
    .capture  (ev_rd_set),
    .cap_data (ret_data),
    .clr_issue(ev_rd_issue),
    .clr_sw   (flag_rd_stb),
    .data_q   (rd_data),
    .valid_q  (rd_valid)
  );

endmodule

// File: rtl/mr_access_chk.sv
module mr_access_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          req_stb,
  input logic          busy,
  input logic          flag_rd_stb,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          cmd_is_read,
  input logic [AW-1:0] cmd_addr,
  input logic [DW-1:0] cmd_wdata,
  input logic          wr_issued,
  input logic          rd_return,
  input logic [DW-1:0] ret_data,
  input logic          ev_accept,
  input logic          ev_rd_set
);

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    ev_accept |=> busy && cmd_valid);

  assert_no_cmd_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cmd_valid);

  assert_cmd_held_R4: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) &&
                                $stable(cmd_wdata) && $stable(cmd_is_read));

  assert_cmd_released_R4: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready |=> !cmd_valid && busy);

  assert_write_release_R5: assert property (@(posedge clk) disable iff (rst)
    busy && !cmd_valid && !cmd_is_read && wr_issued |=> !busy);

  assert_read_release_R6: assert property (@(posedge clk) disable iff (rst)
    busy && !cmd_valid && cmd_is_read && rd_return |=> !busy);

  assert_drop_while_busy_R7: assert property (@(posedge clk) disable iff (rst)
    busy && req_stb |=> $stable(cmd_addr) && $stable(cmd_wdata) && $stable(cmd_is_read));

  assert_data_capture_R8: assert property (@(posedge clk) disable iff (rst)
    busy && !cmd_valid && cmd_is_read && rd_return |=> rd_valid && rd_data == $past(ret_data));

  assert_issue_clears_R9: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready && cmd_is_read |=> !rd_valid);

  assert_clear_on_read_R10: assert property (@(posedge clk) disable iff (rst)
    flag_rd_stb && !ev_rd_set |=> !rd_valid);

  assert_stray_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && (wr_issued || rd_return) |=> busy);

endmodule

bind mr_access_ctl mr_access_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_stb    (req_stb),
  .busy       (busy),
  .flag_rd_stb(flag_rd_stb),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_is_read(cmd_is_read),
  .cmd_addr   (cmd_addr),
  .cmd_wdata  (cmd_wdata),
  .wr_issued  (wr_issued),
  .rd_return  (rd_return),
  .ret_data   (ret_data),
  .ev_accept  (ev_accept),
  .ev_rd_set  (ev_rd_set)
);

// File: tb/mr_access_ctl_test.sv
`timescale 1ns/1ps
module mr_access_ctl_test;

  localparam int AW = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_stb, req_is_read;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          busy, flag_rd_stb, rd_valid;
  logic [DW-1:0] rd_data;
  logic          cmd_valid, cmd_ready, cmd_is_read;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata;
  logic          wr_issued, rd_return;
  logic [DW-1:0] ret_data;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mr_access_ctl #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst(rst), .req_stb(req_stb), .req_is_read(req_is_read),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
    .flag_rd_stb(flag_rd_stb), .rd_valid(rd_valid), .rd_data(rd_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_is_read(cmd_is_read),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .wr_issued(wr_issued),
    .rd_return(rd_return), .ret_data(ret_data)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic quiet();
    req_stb = 0; flag_rd_stb = 0; cmd_ready = 0; wr_issued = 0; rd_return = 0;
  endtask

  logic [DW-1:0] exp_rdata;
  logic          exp_valid;

  initial begin
    rst = 1; quiet(); req_is_read = 0; req_addr = '0; req_wdata = '0; ret_data = '0;
    tick(); tick();
    rst = 0;
    chk("R1 busy", busy, 0);
    chk("R1 cmd_valid", cmd_valid, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 rd_data", rd_data, 0);
    exp_rdata = '0; exp_valid = 0;

    // R10: clear-on-read with the flag already low leaves it low
    flag_rd_stb = 1; tick(); quiet();
    chk("R10 idle read of flag", rd_valid, 0);

    // R11: stray pulses while idle do nothing
    wr_issued = 1; rd_return = 1; ret_data = 8'hEE; tick(); quiet();
    chk("R11 idle pulses busy", busy, 0);
    chk("R11 idle pulses rd_data", rd_data, 0);

    for (int dir = 0; dir < 2; dir++) begin
      for (int rdly = 0; rdly < 4; rdly++) begin
        for (int sdly = 0; sdly < 4; sdly++) begin
          logic [AW-1:0] a;
          logic [DW-1:0] w, r;
          a = AW'((dir * 16 + rdly * 4 + sdly) * 7 + 3);
          w = a ^ 8'hA5;
          r = a + 8'h31;

          req_stb = 1; req_is_read = dir[0]; req_addr = a; req_wdata = w;
          tick(); quiet();
          chk("R2 busy after accept", busy, 1);
          chk("R2 cmd_valid after accept", cmd_valid, 1);
          chk("R3 cmd_is_read", cmd_is_read, dir[0]);
          chk("R3 cmd_addr", cmd_addr, a);
          chk("R3 cmd_wdata", cmd_wdata, w);

          for (int i = 0; i < rdly; i++) begin
            req_stb = 1; req_is_read = ~dir[0]; req_addr = ~a; req_wdata = ~w;
            wr_issued = 1; rd_return = 1; ret_data = 8'h5A;
            tick(); quiet();
            chk("R4 cmd_valid held", cmd_valid, 1);
            chk("R4/R7 cmd_addr held", cmd_addr, a);
            chk("R7 cmd_is_read held", cmd_is_read, dir[0]);
            chk("R11 busy after stray pulse", busy, 1);
            chk("R11 rd_data untouched", rd_data, exp_rdata);
          end

          cmd_ready = 1; tick(); quiet();
          chk("R4 cmd_valid drops after handover", cmd_valid, 0);
          chk("R4 busy after handover", busy, 1);
          if (dir == 1) exp_valid = 0;
          chk("R9 rd_valid after handover", rd_valid, exp_valid);

          for (int i = 0; i < sdly; i++) begin
            req_stb = 1; req_addr = ~a;
            if (dir == 1) wr_issued = 1;
            else begin rd_return = 1; ret_data = 8'hC3; end
            tick(); quiet();
            chk(dir == 1 ? "R6 busy on wrong pulse" : "R5 busy on wrong pulse", busy, 1);
            chk("R8 rd_data unchanged", rd_data, exp_rdata);
            chk("R8 rd_valid unchanged", rd_valid, exp_valid);
          end

          if (dir == 1) begin rd_return = 1; ret_data = r; end
          else wr_issued = 1;
          tick(); quiet();
          chk(dir == 1 ? "R6 busy released" : "R5 busy released", busy, 0);
          if (dir == 1) begin exp_rdata = r; exp_valid = 1; end
          chk("R8 rd_data", rd_data, exp_rdata);
          chk("R8 rd_valid", rd_valid, exp_valid);

          tick(); tick();
          chk("R7 no queued command", cmd_valid, 0);
          chk("R7 busy stays low", busy, 0);

          if (sdly % 2 == 1) begin
            flag_rd_stb = 1; tick(); quiet();
            exp_valid = 0;
            chk("R10 flag cleared by read", rd_valid, 0);
            chk("R10 data kept", rd_data, exp_rdata);
          end
        end
      end
    end

    // R10: set and clear-on-read in the same cycle, set wins
    req_stb = 1; req_is_read = 1; req_addr = 8'h11; tick(); quiet();
    cmd_ready = 1; tick(); quiet();
    rd_return = 1; ret_data = 8'h9C; flag_rd_stb = 1; tick(); quiet();
    chk("R10 set beats clear valid", rd_valid, 1);
    chk("R10 set beats clear data", rd_data, 8'h9C);
    flag_rd_stb = 1; tick(); quiet();
    chk("R10 later read clears", rd_valid, 0);

    // R1: reset in the middle of an operation
    req_stb = 1; req_is_read = 1; tick(); quiet();
    cmd_ready = 1; tick(); quiet();
    rst = 1; tick(); rst = 0;
    chk("R1 busy after mid reset", busy, 0);
    chk("R1 rd_data after mid reset", rd_data, 0);
    chk("R1 rd_valid after mid reset", rd_valid, 0);
    chk("R1 cmd_valid after mid reset", cmd_valid, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule